// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Flow Control

This block turns words written by software into asynchronous serial frames on a single TX line. A one-word holding buffer sits in front of a frame shift register, so software can queue the next word while the current one is still going out, and consecutive frames leave the line with no idle time between them. Word length (8 or 9 bits), a parity bit (even or odd) and the number of stop bits (one or two) are chosen per frame; the setting in force when a word enters the shift register governs that whole frame.

A bit period is derived from the system clock by a prescaler (undivided, divide by 8, or divide by twice a 4-bit value) followed by a programmable divider and a fixed 16x oversampling count. An active-low clear-to-send input, resynchronized by two flops, gates the start of every frame: a frame in flight always completes, and the next one waits until the peer allows it. The flow-control gate can be switched off. A transmit enable works the same way: clearing it lets the current frame end and keeps the line idle high.

Status is given by a buffer-empty flag and a transmit-done flag. A single interrupt request is raised either when a word moves from the holding buffer into the shift register, or when the transmitter becomes fully idle, and stays raised until acknowledged.

Top module: `uart_tx_cts`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits, all high; `txd` is high whenever no frame is being sent.
- R2: With `nine_bit`=1 nine data bits `wr_data[8:0]` are sent; with `nine_bit`=0 eight bits `wr_data[7:0]` are sent and `wr_data[8]` has no effect on the line.
- R3: With `par_en`=1 one parity bit follows the last data bit, chosen so that the number of ones over data plus parity is even when `par_odd`=0 and odd when `par_odd`=1; with `par_en`=0 no parity bit is sent.
- R4: `two_stop`=0 gives one stop bit and `two_stop`=1 gives two.
- R5: Every bit lasts exactly 16 x (`brg_m`+1) x D clock cycles, where D is 1 for `src_sel`=00 or 11, 8 for `src_sel`=01, and for `src_sel`=10 D is 2 x `pre_n`, or 1 when `pre_n`=0.
- R6: With `cts_off`=0 a frame starts only while the synchronized `cts_n` is low; a frame already in progress completes even if `cts_n` rises, and a held word starts on the third clock edge after `cts_n` falls.
- R7: With `cts_off`=1 the `cts_n` input has no effect and a written word starts on the next edge after it is in the buffer.
- R8: A write clears `buf_empty` from the following cycle; `buf_empty` sets again on the edge where the word moves into the shift register; a word waiting at the end of a frame starts with its start bit directly after the previous last stop bit.
- R9: `tx_done` is 1 only when no frame is in progress and no word is held in the buffer.
- R10: With `irq_sel`=0 `irq` sets on the edge where a word moves into the shift register; with `irq_sel`=1 it sets on the edge where `tx_done` goes from 0 to 1; once set it stays 1 until a cycle with `irq_ack`=1, after which it is 0.
- R11: With `tx_en`=0 no new frame starts and the held word stays held; a frame in progress when `tx_en` falls completes.
- R12: After reset `txd`=1, `buf_empty`=1, `tx_done`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; 0 stops new frames |
| nine_bit | input | 1 | 1 = nine data bits, 0 = eight |
| par_en | input | 1 | 1 = append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| src_sel | input | 2 | Prescaler source: 00 undivided, 01 divide by 8, 10 divide by 2 x pre_n, 11 undivided |
| pre_n | input | PRE_W | Prescaler value for src_sel=10 |
| brg_m | input | DIV_W | Bit-rate divider value m |
| cts_off | input | 1 | 1 = ignore cts_n |
| cts_n | input | 1 | Active-low clear-to-send from the peer, asynchronous |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Word to transmit |
| irq_sel | input | 1 | Interrupt source: 0 word taken from buffer, 1 transmitter idle |
| irq_ack | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding buffer empty |
| tx_done | output | 1 | No frame in progress and buffer empty |
| irq | output | 1 | Interrupt request |

## Verification
A bit counter or frame length that is off shows up within one frame as a shifted or missing parity or stop bit, which the bench catches by comparing `txd` against the expected frame on every single clock cycle of it, so a bit period that is one cycle short or long is also visible at once. A stuck or wrong buffer-full state shows up within a cycle or two as a wrong `buf_empty`, as a gap or overlap between back-to-back frames, or as a word that starts while the flow-control or enable gate is closed. An interrupt latch fault appears as an `irq` that fails to set on the cycle of the selected event or fails to stay set until the acknowledge.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    // Prescaler source choice; the code values are visible at the top ports.
    typedef enum logic [1:0] {
        SRC_FULL  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV2N = 2'b10,
        SRC_ALT   = 2'b11
    } src_sel_e;

    // Per-frame format, latched when a word enters the shift register.
    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } fmt_t;

    localparam int OVS = 16;  // clock ticks per bit after the divider

endpackage

// File: rtl/uatx_sync.sv
module uatx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d = {st_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/uatx_baud.sv
module uatx_baud
    import uatx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  src_sel_e         src,
    input  logic [PRE_W-1:0] pre_n,
    input  logic [DIV_W-1:0] brg_m,
    output logic             bit_tick
);
    localparam int PC_W = (PRE_W + 1 > 4) ? PRE_W + 1 : 4;
    localparam int PH_W = $clog2(OVS);

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [DIV_W-1:0] dv;
        logic [PH_W-1:0]  ph;
    } baud_st_t;

    baud_st_t s_d, s_q;
    logic [PC_W-1:0] lim;
    logic            src_tick;

    always_comb begin
        case (src)
            SRC_DIV8:  lim = PC_W'(7);
            SRC_DIV2N: lim = (pre_n == '0) ? '0 : PC_W'({pre_n, 1'b0}) - PC_W'(1);
            default:   lim = '0;
        endcase
        src_tick = (s_q.pc == lim);
        bit_tick = run && src_tick && (s_q.dv == brg_m) && (s_q.ph == PH_W'(OVS - 1));

        s_d = s_q;
        if (!run) begin
            s_d = '0;
        end else if (src_tick) begin
            s_d.pc = '0;
            if (s_q.dv == brg_m) begin
                s_d.dv = '0;
                s_d.ph = s_q.ph + PH_W'(1);
            end else begin
                s_d.dv = s_q.dv + DIV_W'(1);
            end
        end else begin
            s_d.pc = s_q.pc + PC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uatx_engine.sv
module uatx_engine
    import uatx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  fmt_t              fmt,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cts_ok,
    input  logic              irq_sel,
    input  logic              irq_ack,
    input  logic              bit_tick,
    output logic              txd,
    output logic              busy,
    output logic              load,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq
);
    localparam int FRM_W = DATA_W + 4;
    localparam int CNT_W = $clog2(FRM_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              full;
        logic              busy;
        logic [FRM_W-1:0]  sh;
        logic [CNT_W-1:0]  cnt;
        logic              irq;
    } eng_st_t;

    eng_st_t s_d, s_q;

    // Frame image, bit 0 leaves first; unused upper bits stay high (stop/idle).
    function automatic logic [FRM_W-1:0] build_frame(logic [DATA_W-1:0] d, fmt_t f);
        logic [FRM_W-1:0] v;
        logic             par;
        v = '1;
        if (f.nine) begin
            par = (^d) ^ f.par_odd;
            v[DATA_W:0] = {d, 1'b0};
            if (f.par_en) v[DATA_W+1] = par;
        end else begin
            par = (^d[DATA_W-2:0]) ^ f.par_odd;
            v[DATA_W-1:0] = {d[DATA_W-2:0], 1'b0};
            if (f.par_en) v[DATA_W] = par;
        end
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(fmt_t f);
        logic [CNT_W-1:0] n;
        n = f.nine ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
        if (f.par_en)   n = n + CNT_W'(1);
        n = n + (f.two_stop ? CNT_W'(2) : CNT_W'(1));
        return n;
    endfunction

    logic start_ok, frame_end, ev, done_now, done_next;

    always_comb begin
        s_d       = s_q;
        start_ok  = s_q.full && tx_en && cts_ok;
        frame_end = s_q.busy && bit_tick && (s_q.cnt == CNT_W'(1));
        load      = start_ok && (!s_q.busy || frame_end);

        if (s_q.busy && bit_tick) begin
            s_d.sh  = {1'b1, s_q.sh[FRM_W-1:1]};
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (frame_end) s_d.busy = 1'b0;
        end
        if (load) begin
            s_d.sh   = build_frame(s_q.hold, fmt);
            s_d.cnt  = frame_len(fmt);
            s_d.busy = 1'b1;
            s_d.full = 1'b0;
        end
        if (wr_en) begin
            s_d.hold = wr_data;
            s_d.full = 1'b1;
        end

        done_now  = !s_q.busy && !s_q.full;
        done_next = !s_d.busy && !s_d.full;
        ev        = irq_sel ? (done_next && !done_now) : load;
        s_d.irq   = (s_q.irq && !irq_ack) || ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sh   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd       = s_q.sh[0];
    assign busy      = s_q.busy;
    assign buf_empty = !s_q.full;
    assign tx_done   = !s_q.busy && !s_q.full;
    assign irq       = s_q.irq;
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
    import uatx_pkg::*;
#(
    parameter int DATA_W      = 9,
    parameter int DIV_W       = 8,
    parameter int PRE_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic [1:0]        src_sel,
    input  logic [PRE_W-1:0]  pre_n,
    input  logic [DIV_W-1:0]  brg_m,
    input  logic              cts_off,
    input  logic              cts_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_sel,
    input  logic              irq_ack,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq
);
    logic cts_s, cts_ok, bit_tick, busy, load;
    fmt_t fmt;

    assign fmt    = '{nine: nine_bit, par_en: par_en, par_odd: par_odd, two_stop: two_stop};
    assign cts_ok = cts_off || !cts_s;

    uatx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_n),
        .q     (cts_s)
    );

    uatx_baud #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .src      (src_sel_e'(src_sel)),
        .pre_n    (pre_n),
        .brg_m    (brg_m),
        .bit_tick (bit_tick)
    );

    uatx_engine #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .fmt       (fmt),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cts_ok    (cts_ok),
        .irq_sel   (irq_sel),
        .irq_ack   (irq_ack),
        .bit_tick  (bit_tick),
        .txd       (txd),
        .busy      (busy),
        .load      (load),
        .buf_empty (buf_empty),
        .tx_done   (tx_done),
        .irq       (irq)
    );
endmodule

// File: rtl/uart_tx_cts_chk.sv
module uart_tx_cts_chk (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic tx_done,
    input logic buf_empty,
    input logic irq,
    input logic irq_ack,
    input logic wr_en,
    input logic tx_en,
    input logic cts_n,
    input logic cts_off,
    input logic busy,
    input logic load
);
    // Edges since reset release, saturating, so $past never reaches before reset.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R6 (two synchronizer stages)
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cts_off && age_q == 2'd3) |-> !$past(cts_n, 2));

    // R11
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $rose(busy)) |-> $past(tx_en));

    // R8
    load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> buf_empty);

    // R1
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);
endmodule

bind uart_tx_cts uart_tx_cts_chk u_chk (.*);

// File: tb/uart_tx_cts_bench.sv
`timescale 1ns/1ps
module uart_tx_cts_bench;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       tx_en = 1'b0, nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] pre_n = 4'd0;
    logic [7:0] brg_m = 8'd0;
    logic       cts_off = 1'b0, cts_n = 1'b0, wr_en = 1'b0, irq_sel = 1'b0, irq_ack = 1'b0;
    logic [8:0] wr_data = 9'd0;
    logic       txd, buf_empty, tx_done, irq;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    uart_tx_cts u_uart_tx_cts (.*);

    // Vector: {data[26:18], nine[17], par[16], odd[15], two[14], sel[13:12], n[11:8], m[7:0]}
    localparam int NV = 8;
    localparam logic [26:0] VEC [NV] = '{
        {9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0},  // R1 plain 8N1
        {9'h1C3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd0, 8'd1},  // R2 R4 9N2
        {9'h1FF, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 8'd0},  // R2 bit8 dropped, R3 even
        {9'h0B7, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 8'd2},  // R3 odd, 9 bits
        {9'h05A, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 4'd0, 8'd0},  // R5 divide by 8
        {9'h133, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 4'd3, 8'd0},  // R5 divide by 6
        {9'h066, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 4'd0, 8'd1},  // R5 n=0 undivided
        {9'h0F0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 4'd9, 8'd0}   // R5 code 11 undivided
    };

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int period(input logic [26:0] v);
        int d;
        case (v[13:12])
            2'd1:    d = 8;
            2'd2:    d = (v[11:8] == 4'd0) ? 1 : 2 * int'(v[11:8]);
            default: d = 1;
        endcase
        return 16 * (int'(v[7:0]) + 1) * d;
    endfunction

    function automatic int flen(input logic [26:0] v);
        return 1 + (v[17] ? 9 : 8) + (v[16] ? 1 : 0) + (v[14] ? 2 : 1);
    endfunction

    function automatic logic ebit(input logic [26:0] v, input int idx);
        int   dl = v[17] ? 9 : 8;
        logic p  = v[15];
        for (int i = 0; i < dl; i++) p ^= v[18 + i];
        if (idx == 0)                return 1'b0;
        if (idx <= dl)               return v[18 + idx - 1];
        if (idx == dl + 1 && v[16])  return p;
        return 1'b1;
    endfunction

    task automatic apply_cfg(input logic [26:0] v);
        nine_bit = v[17]; par_en = v[16]; par_odd = v[15]; two_stop = v[14];
        src_sel = v[13:12]; pre_n = v[11:8]; brg_m = v[7:0];
    endtask

    task automatic wr(input logic [8:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr2(input logic [8:0] a, input logic [8:0] b);
        wr_en = 1'b1; wr_data = a;
        @(negedge clk);
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Compare txd on every cycle of one frame; ends on the first cycle after it.
    task automatic capture(input logic [26:0] v, input bit wait_fall, input string req, output int lat);
        int p = period(v);
        int l = flen(v);
        int bad = 0, first = -1;
        logic ga = 1'b0, ge = 1'b0;
        lat = 0;
        if (wait_fall) begin
            while (txd !== 1'b0 && lat < 20000) begin
                @(negedge clk);
                lat++;
            end
        end
        for (int c = 0; c < l * p; c++) begin
            logic e = ebit(v, c / p);
            if (txd !== e) begin
                if (first < 0) begin first = c; ga = txd; ge = e; end
                bad++;
            end
            @(negedge clk);
        end
        if (bad != 0)
            $display("  first mismatch at cycle %0d of frame: txd=%0b expected %0b", first, ga, ge);
        check(bad == 0, req, "mismatching frame cycles", bad, 0);
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            if (txd !== 1'b1) lows++;
            @(negedge clk);
        end
    endtask

    task automatic wait_done();
        int k = 0;
        while (tx_done !== 1'b1 && k < 20000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    initial begin
        int lat, lows;
        logic [26:0] c0;
        c0 = VEC[0];

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(txd == 1'b1,       "R12", "txd after reset",       int'(txd), 1);
        check(buf_empty == 1'b1, "R12", "buf_empty after reset", int'(buf_empty), 1);
        check(tx_done == 1'b1,   "R12", "tx_done after reset",   int'(tx_done), 1);
        check(irq == 1'b0,       "R12", "irq after reset",       int'(irq), 0);

        tx_en = 1'b1;
        // Table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            apply_cfg(VEC[i]);
            wr(VEC[i][26:18]);
            capture(VEC[i], 1'b1, "R1/R2/R3/R4/R5", lat);
            check(txd == 1'b1,    "R1", "txd idle after frame",    int'(txd), 1);
            check(tx_done == 1'b1, "R9", "tx_done after frame",    int'(tx_done), 1);
        end

        // R8 back-to-back frames, R9 busy
        apply_cfg(c0);
        wr2(9'h0A5, 9'h0A5);
        check(buf_empty == 1'b0, "R8", "buf_empty with second word held", int'(buf_empty), 0);
        check(tx_done == 1'b0,   "R9", "tx_done while sending",          int'(tx_done), 0);
        capture(c0, 1'b0, "R8", lat);
        check(buf_empty == 1'b1, "R8", "buf_empty after second word moved", int'(buf_empty), 1);
        capture(c0, 1'b0, "R8", lat);  // must start with no idle cycle
        check(txd == 1'b1, "R8", "idle after two frames", int'(txd), 1);

        // R10 source = word taken
        irq_sel = 1'b0;
        ack();
        check(irq == 1'b0, "R10", "irq after ack", int'(irq), 0);
        wr(9'h011);
        check(buf_empty == 1'b0, "R8", "buf_empty cycle after write", int'(buf_empty), 0);
        check(irq == 1'b0, "R10", "irq before transfer", int'(irq), 0);
        @(negedge clk);
        check(irq == 1'b1, "R10", "irq on transfer (sel0)", int'(irq), 1);
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R10", "irq held until ack", int'(irq), 1);
        wait_done();
        ack();
        check(irq == 1'b0, "R10", "irq cleared by ack", int'(irq), 0);

        // R10 source = idle
        irq_sel = 1'b1;
        wr(9'h022);
        @(negedge clk);
        check(irq == 1'b0, "R10", "irq low while sending (sel1)", int'(irq), 0);
        wait_done();
        check(irq == 1'b1, "R10", "irq on done (sel1)", int'(irq), 1);
        ack();
        irq_sel = 1'b0;

        // R6 hold while CTS high, release latency
        cts_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(9'h0A5);
        count_low(100, lows);
        check(lows == 0,         "R6", "txd low cycles while CTS high", lows, 0);
        check(buf_empty == 1'b0, "R6", "word still held",               int'(buf_empty), 0);
        cts_n = 1'b0;
        capture(c0, 1'b1, "R6", lat);
        check(lat == 3, "R6", "start latency after CTS low", lat, 3);

        // R6 frame in progress completes, next held
        wr2(9'h0A5, 9'h0A5);
        cts_n = 1'b1;
        capture(c0, 1'b0, "R6", lat);
        count_low(50, lows);
        check(lows == 0,         "R6", "no second frame while CTS high", lows, 0);
        check(buf_empty == 1'b0, "R6", "second word held",              int'(buf_empty), 0);
        cts_n = 1'b0;
        capture(c0, 1'b1, "R6", lat);

        // R7 CTS ignored when disabled
        cts_off = 1'b1;
        cts_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(9'h0A5);
        capture(c0, 1'b1, "R7", lat);
        check(lat == 1, "R7", "start latency with CTS off", lat, 1);
        cts_off = 1'b0;
        cts_n = 1'b0;
        repeat (3) @(negedge clk);

        // R11 enable low blocks start
        tx_en = 1'b0;
        wr(9'h0A5);
        count_low(60, lows);
        check(lows == 0,         "R11", "txd low cycles while disabled", lows, 0);
        check(buf_empty == 1'b0, "R11", "word held while disabled",      int'(buf_empty), 0);
        check(tx_done == 1'b0,   "R9",  "tx_done with word held",        int'(tx_done), 0);
        tx_en = 1'b1;
        capture(c0, 1'b1, "R11", lat);

        // R11 disable mid-frame
        wr2(9'h0A5, 9'h0A5);
        tx_en = 1'b0;
        capture(c0, 1'b0, "R11", lat);
        count_low(60, lows);
        check(lows == 0,         "R11", "no new frame after disable", lows, 0);
        check(buf_empty == 1'b0, "R11", "second word kept",           int'(buf_empty), 0);
        tx_en = 1'b1;
        capture(c0, 1'b1, "R11", lat);

        report();
        $finish;
    end
endmodule